// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block runs next to a page-mode DRAM controller and owns the refresh side of the device. After reset it waits out the supply settling time. It then issues a burst of initialization cycles. From then on it paces CAS-before-RAS (CBR) refresh cycles so that every row is refreshed inside the retention window. The device's internal row counter supplies the refresh address, so the block drives no address lines.

The controller and this block share the RAS and CAS strobes. Whenever refresh work is owed, the block raises a bus request and waits for a grant. It then runs all the work it owes back to back and drops the request. The interval timer keeps running while the grant is held off, and missed intervals become debt. If the debt saturates, the retention guarantee is gone, and the block repeats the full initialization burst.

On a sleep request the block parks the device in self refresh. It holds RAS and CAS low after a CBR start, acknowledges once the minimum hold time has passed, and on release restores RAS and keeps the bus through a precharge gap. Every timing is a parameter counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and just after it, ras_no=1, cas_no=1, ref_req_o=0 and sleep_ack_o=0.
- R2: For PWRUP_CYC cycles after reset no request is raised and no strobe moves. The first RAS fall comes exactly 3 cycles after that wait ends (one idle cycle, one request cycle, CSR_CYC=1 cycle of CAS lead).
- R3: After the wait, exactly INIT_CYC refresh cycles run back to back, one RAS fall every CSR_CYC+RAS_CYC+PRE_CYC cycles. ref_req_o is then dropped and no further cycle runs until the interval timer expires.
- R4: Every RAS fall (active low) is preceded by CAS already low for at least one cycle, which is CBR order. CAS never rises before RAS during a refresh.
- R5: In a refresh, RAS is low for exactly RAS_CYC cycles. Between two back-to-back refreshes RAS is high for exactly PRE_CYC+CSR_CYC cycles.
- R6: Once initialization is complete and the grant is given at once, successive periodic RAS falls are exactly INTERVAL cycles apart.
- R7: Strobes move only after ref_gnt_i has been seen with ref_req_o high. While the grant is withheld, ref_req_o stays high and the interval timer keeps counting, so each missed interval adds one owed refresh. After the grant, all owed refreshes run back to back and the request is then dropped.
- R8: If an interval expires while OWED_MAX refreshes are already owed, the debt is discarded. A full burst of INIT_CYC back-to-back refreshes then runs once the grant comes.
- R9: A sleep request while nothing is owed starts a CBR entry that keeps RAS and CAS low. sleep_ack_o rises in the SREF_CYC-th cycle of RAS low, which is SREF_CYC-1 cycles after the RAS fall is first seen.
- R10: While sleep_request stays high after entry, RAS stays low, no further RAS edge occurs and no periodic refresh is issued.
- R11: When the sleep request falls after the acknowledge, RAS and CAS go high and sleep_ack_o clears one cycle later. ref_req_o stays high for SREF_PRE_CYC cycles of precharge and is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_req_o | output | 1 | Request for the shared strobe bus |
| ref_gnt_i | input | 1 | Bus grant from the page-mode controller |
| sleep_req_i | input | 1 | Request to enter and stay in self refresh |
| sleep_ack_o | output | 1 | Device is in self refresh |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe (one byte lane), active low |

## Verification
The refresh engine is first driven with an always-present grant. This separates the initialization burst from the periodic cadence, because the spacing between RAS falls is 4 cycles in one and INTERVAL cycles in the other. Withholding the grant across two intervals shows that the debt is kept and paid back to back. Withholding it across four intervals shows that saturation re-runs the full burst of eight instead of paying a few owed cycles. A sleep request placed between refreshes checks entry timing, a long hold with no RAS edge, and the exit precharge, measured from the release of the request.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_REQ,
    ST_CAS,
    ST_RAS,
    ST_PRE,
    ST_SLEEP,
    ST_EXIT
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned W = $clog2(INTERVAL);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == W'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int unsigned OWED_MAX = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tick_i,
  input  logic                             done_i,
  output logic [$clog2(OWED_MAX+1)-1:0]    owed_o,
  output logic                             lost_o
);
  localparam int unsigned W = $clog2(OWED_MAX + 1);

  logic [W-1:0] owed_q;

  assign owed_o = owed_q;
  assign lost_o = tick_i && (owed_q == W'(OWED_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 owed_q <= '0;
    else if (lost_o)             owed_q <= '0;
    else if (tick_i && !done_i)  owed_q <= owed_q + 1'b1;
    else if (done_i && !tick_i)  owed_q <= owed_q - 1'b1;
  end

  assert_owed_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= W'(OWED_MAX));

  assert_done_has_debt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (owed_q != '0));

endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm import dram_ref_pkg::*; #(
  parameter int unsigned PWRUP_CYC    = 10000,
  parameter int unsigned INIT_CYC     = 8,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned RAS_CYC      = 2,
  parameter int unsigned PRE_CYC      = 1,
  parameter int unsigned SREF_CYC     = 5001,
  parameter int unsigned SREF_PRE_CYC = 3,
  parameter int unsigned OWED_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OWED_W-1:0] owed_i,
  input  logic              lost_i,
  input  logic              ref_gnt_i,
  input  logic              sleep_req_i,
  output logic              ref_req_o,
  output logic              sleep_ack_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              run_o,
  output logic              done_o
);
  localparam int unsigned CNT_MAX = max_u(max_u(max_u(PWRUP_CYC, SREF_CYC), max_u(CSR_CYC, RAS_CYC)),
                                          max_u(PRE_CYC, SREF_PRE_CYC));
  localparam int unsigned CNT_W  = $clog2(CNT_MAX + 1);
  localparam int unsigned INIT_W = $clog2(INIT_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [INIT_W-1:0] init_q;
  logic              cnt_zero, need_ref, ras_end;

  function automatic logic [CNT_W-1:0] ld(input int unsigned n);
    return CNT_W'(n - 1);
  endfunction

  assign cnt_zero = (cnt_q == '0);
  assign need_ref = (init_q != '0) || (owed_i != '0);
  assign ras_end  = (state_q == ST_RAS) && cnt_zero;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    case (state_q)
      ST_PWRUP: if (cnt_zero) state_d = ST_IDLE;
      ST_IDLE:  if (need_ref || sleep_req_i) state_d = ST_REQ;
      ST_REQ:   if (ref_gnt_i) begin state_d = ST_CAS; cnt_d = ld(CSR_CYC); end
      ST_CAS: if (cnt_zero) begin
        // refresh debt wins over sleep entry
        if (!need_ref && sleep_req_i) begin state_d = ST_SLEEP; cnt_d = ld(SREF_CYC); end
        else                          begin state_d = ST_RAS;   cnt_d = ld(RAS_CYC);  end
      end
      ST_RAS: if (cnt_zero) begin state_d = ST_PRE; cnt_d = ld(PRE_CYC); end
      ST_PRE: if (cnt_zero) begin
        if (need_ref || sleep_req_i) begin state_d = ST_CAS; cnt_d = ld(CSR_CYC); end
        else                           state_d = ST_IDLE;
      end
      ST_SLEEP: if (cnt_zero && !sleep_req_i) begin state_d = ST_EXIT; cnt_d = ld(SREF_PRE_CYC); end
      ST_EXIT:  if (cnt_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      cnt_q   <= ld(PWRUP_CYC);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        init_q <= INIT_W'(INIT_CYC);
    else if (lost_i)                    init_q <= INIT_W'(INIT_CYC);
    else if (ras_end && init_q != '0)   init_q <= init_q - 1'b1;
  end

  assign done_o      = ras_end && (init_q == '0) && (owed_i != '0);
  assign run_o       = (init_q == '0) && !(state_q inside {ST_PWRUP, ST_SLEEP, ST_EXIT});
  assign ras_no      = !(state_q inside {ST_RAS, ST_SLEEP});
  assign cas_no      = !(state_q inside {ST_CAS, ST_RAS, ST_SLEEP});
  assign ref_req_o   = !(state_q inside {ST_PWRUP, ST_IDLE});
  assign sleep_ack_o = (state_q == ST_SLEEP) && cnt_zero;

  assert_cbr_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $past(!cas_no));

  assert_gnt_before_cas_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> $past(ref_gnt_i));

  assert_ack_after_ras_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_ack_o) |-> $past(!ras_no));

  assert_exit_bus_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_ack_o) |-> (ref_req_o && ras_no));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq import dram_ref_pkg::*; #(
  parameter int unsigned PWRUP_CYC    = 10000,
  parameter int unsigned INIT_CYC     = 8,
  parameter int unsigned INTERVAL     = 780,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned RAS_CYC      = 2,
  parameter int unsigned PRE_CYC      = 1,
  parameter int unsigned SREF_CYC     = 5001,
  parameter int unsigned SREF_PRE_CYC = 3,
  parameter int unsigned OWED_MAX     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ref_req_o,
  input  logic ref_gnt_i,
  input  logic sleep_req_i,
  output logic sleep_ack_o,
  output logic ras_no,
  output logic cas_no
);
  localparam int unsigned OWED_W = $clog2(OWED_MAX + 1);

  logic              run, tick, done, lost;
  logic [OWED_W-1:0] owed;

  ref_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  ref_debt_ctr #(.OWED_MAX(OWED_MAX)) u_debt (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .done_i(done),
    .owed_o(owed), .lost_o(lost)
  );

  ref_seq_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .INIT_CYC(INIT_CYC), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC),
    .PRE_CYC(PRE_CYC), .SREF_CYC(SREF_CYC), .SREF_PRE_CYC(SREF_PRE_CYC), .OWED_W(OWED_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .owed_i     (owed),
    .lost_i     (lost),
    .ref_gnt_i  (ref_gnt_i),
    .sleep_req_i(sleep_req_i),
    .ref_req_o  (ref_req_o),
    .sleep_ack_o(sleep_ack_o),
    .ras_no     (ras_no),
    .cas_no     (cas_no),
    .run_o      (run),
    .done_o     (done)
  );

endmodule

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int PWRUP = 20, INIT = 8, IVL = 40, CSR = 1, RASC = 2, PRE = 1;
  localparam int SREF = 30, SPRE = 3, OMAX = 3, CYC_REF = CSR + RASC + PRE;

  logic clk = 1'b0, rst_n = 1'b0, gnt_en = 1'b1, sleep_req = 1'b0;
  logic req, gnt, ack, ras_n, cas_n;
  assign gnt = req & gnt_en;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CYC(INIT), .INTERVAL(IVL), .CSR_CYC(CSR), .RAS_CYC(RASC),
    .PRE_CYC(PRE), .SREF_CYC(SREF), .SREF_PRE_CYC(SPRE), .OWED_MAX(OMAX)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_req_o(req), .ref_gnt_i(gnt),
    .sleep_req_i(sleep_req), .sleep_ack_o(ack), .ras_no(ras_n), .cas_no(cas_n)
  );

  int checks = 0, fails = 0, cyc = 0;
  int falls = 0, rises = 0, last_fall = 0, prev_fall = 0;
  int low_run = 0, high_run = 0, last_low_w = 0, last_high_w = 0, cbr_bad = 0;
  logic ras_q = 1'b1, cas_q = 1'b1;
  bit finished = 0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  // strobe monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_q && !ras_n) begin
        falls++; prev_fall = last_fall; last_fall = cyc; last_high_w = high_run;
        if (cas_q) cbr_bad++;
      end
      if (!ras_q && ras_n) begin rises++; last_low_w = low_run; end
      if (!ras_n) begin low_run++; high_run = 0; end
      else begin low_run = 0; high_run++; end
      ras_q = ras_n; cas_q = cas_n;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_fall(input string tag);
    int f0 = falls;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (falls != f0) return;
    end
    chk(tag, 0, 1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 ras", ras_n, 1); chk("R1 cas", cas_n, 1);
    chk("R1 req", req, 0);   chk("R1 ack", ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ras after release", ras_n, 1); chk("R1 req after release", req, 0);
  endtask

  task automatic t_powerup;
    int bad = 0;
    for (int i = 0; i < PWRUP - 2; i++) begin
      @(negedge clk);
      if (req || !ras_n || !cas_n) bad++;
    end
    chk("R2 quiet during wait", bad, 0);
    wait_fall("R2 first fall");
    chk("R2 first fall cycle", last_fall, PWRUP + 3);
  endtask

  task automatic t_init;
    for (int i = 0; i < 200 && falls < INIT; i++) @(negedge clk);
    chk("R3 burst gap", last_fall - prev_fall, CYC_REF);
    chk("R5 high between refreshes", last_high_w, PRE + CSR);
    repeat (6) @(negedge clk);
    chk("R5 ras low width", last_low_w, RASC);
    chk("R3 burst count", falls, INIT);
    chk("R3 bus released", req, 0);
    chk("R4 cbr order", cbr_bad, 0);
  endtask

  task automatic t_periodic;
    wait_fall("R6 fall a");
    wait_fall("R6 fall b");
    chk("R6 interval", last_fall - prev_fall, IVL);
    wait_fall("R6 fall c");
    chk("R6 interval again", last_fall - prev_fall, IVL);
    chk("R4 cbr order periodic", cbr_bad, 0);
  endtask

  task automatic t_withhold;
    int f0;
    wait_fall("R7 sync");
    repeat (8) @(negedge clk);
    gnt_en = 1'b0; f0 = falls;
    repeat (80) @(negedge clk);
    chk("R7 no strobe without grant", falls, f0);
    chk("R7 request held", req, 1);
    chk("R7 cas idle without grant", cas_n, 1);
    gnt_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R7 owed refreshes issued", falls, f0 + 2);
    chk("R7 owed back to back", last_fall - prev_fall, CYC_REF);
    chk("R7 request dropped", req, 0);
  endtask

  task automatic t_overflow;
    int f0;
    wait_fall("R8 sync");
    repeat (8) @(negedge clk);
    gnt_en = 1'b0; f0 = falls;
    repeat (170) @(negedge clk);
    chk("R8 no strobe while withheld", falls, f0);
    gnt_en = 1'b1;
    repeat (36) @(negedge clk);
    chk("R8 full init burst rerun", falls, f0 + INIT);
    chk("R8 burst spacing", last_fall - prev_fall, CYC_REF);
  endtask

  task automatic t_sleep;
    int f0, r0, f1, waited;
    wait_fall("R9 sync");
    repeat (8) @(negedge clk);
    sleep_req = 1'b1; f0 = falls;
    repeat (10) @(negedge clk);
    chk("R9 ras low", ras_n, 0); chk("R9 cas low", cas_n, 0);
    chk("R9 no early ack", ack, 0); chk("R9 one entry fall", falls, f0 + 1);
    waited = 0;
    while (!ack && waited < 200) begin @(negedge clk); waited++; end
    chk("R9 ack timing", cyc - last_fall, SREF - 1);
    r0 = rises; f1 = falls;
    repeat (150) @(negedge clk);
    chk("R10 no ras rise", rises, r0); chk("R10 no refresh", falls, f1);
    chk("R10 ras held", ras_n, 0);     chk("R10 ack held", ack, 1);
    sleep_req = 1'b0;
    @(negedge clk);
    chk("R11 ras up", ras_n, 1); chk("R11 ack clear", ack, 0); chk("R11 bus held", req, 1);
    repeat (2) @(negedge clk);
    chk("R11 bus held in precharge", req, 1);
    @(negedge clk);
    chk("R11 bus released", req, 0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_init();
    t_periodic();
    t_withhold();
    t_overflow();
    t_sleep();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule